// File: doc/BRIEF.md
# Per-Port Digital Glitch Filter Bank

This block holds one glitch filter for each pin of a port. Each pin is first brought through a two-stage synchronizer. Its filtered output then moves to the synchronized value only after the two have disagreed for a programmable run of filter ticks. Every lane in the port shares one filter width and one choice of filter clock: either the bus-clock tick or the low-power-clock tick. Each lane has its own enable.

The whole block runs on a single system clock. The two filter clocks arrive as single-cycle tick strobes, and only the selected strobe advances the lanes. The width and the clock choice may be changed only while every lane is disabled.

In stop mode the behaviour depends on the clock choice. With the bus tick selected, each enabled lane passes its raw pin straight to its output, and the lane's synchronizer, counter and output register hold their values. With the low-power tick selected, stop mode has no effect and filtering goes on as normal.

Top module: `port_glitch_filter`

## Requirements
- R1: Lanes advance only on the tick strobe chosen by `clk_sel_i`: 0 selects `tick_bus_i` and 1 selects `tick_lp_i`. Pulses on the other strobe have no effect on any output.
- R2: Every output is 0 during reset and after reset. An output is also 0 in the same cycle that its enable is low, whatever its pin does. A lane that is enabled again starts from output 0.
- R3: Each lane responds only to its own enable bit and its own pin bit.
- R4: A pin pulse lasting L ticks reaches the output only if L is at least W+1, where W is `width_i`.
- R5: A steady change on a pin appears at the output after exactly W+3 selected ticks, and not one tick earlier. This holds for rising and falling changes alike.
- R6: When W is 0, a steady change appears after 3 ticks and not after 2.
- R7: With the bus tick selected and `stop_i` high, each enabled output equals its raw pin with no clock delay. Disabled outputs stay 0.
- R8: During that bypass the lane state stays frozen. When stop ends, each output shows its value from before the stop, and it then needs the full W+3 ticks to follow the pin.
- R9: With the low-power tick selected, `stop_i` does not change filtering: there is no bypass and the latency is still W+3 ticks.
- R10: Any tick on which the synchronized input agrees with the output clears the disagreement count. Two runs of W disagreeing ticks separated by one agreeing tick therefore do not pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | N_PINS | Raw pin levels |
| en_i | input | N_PINS | Per-lane filter enable |
| width_i | input | 5 | Shared filter width W, in ticks |
| clk_sel_i | input | 1 | Filter clock choice: 0 bus tick, 1 low-power tick |
| stop_i | input | 1 | Stop-mode indicator |
| tick_bus_i | input | 1 | Bus-clock tick strobe |
| tick_lp_i | input | 1 | Low-power-clock tick strobe |
| filt_o | output | N_PINS | Filtered pin levels |

## Verification
The bench builds the block with N_PINS = 4 and the default 5-bit width. This allows the full width range from 0 up to 31 ticks. Each pulse-length vector is driven onto all four pins at once, so every lane is checked against the same expected value. Four lanes are also enough for mixed enable masks, which show that enables are independent and that a disabled lane stays 0 during bypass.

// File: rtl/pgf_pkg.sv
`timescale 1ns/1ps
package pgf_pkg;
    localparam int unsigned FW_W = 5;

    typedef struct packed {
        logic            s1;
        logic            s2;
        logic [FW_W-1:0] cnt;
        logic            out;
    } lane_st_t;
endpackage

// File: rtl/pgf_tick_sel.sv
`timescale 1ns/1ps
module pgf_tick_sel (
    input  logic clk_sel_i,
    input  logic stop_i,
    input  logic tick_bus_i,
    input  logic tick_lp_i,
    output logic adv_o,
    output logic frz_o
);
    logic tick_pick;

    always_comb begin
        tick_pick = clk_sel_i ? tick_lp_i : tick_bus_i;
        frz_o     = stop_i && !clk_sel_i;
        adv_o     = tick_pick && !frz_o;
    end
endmodule

// File: rtl/pgf_lane.sv
`timescale 1ns/1ps
module pgf_lane
    import pgf_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pin_i,
    input  logic            en_i,
    input  logic            adv_i,
    input  logic            frz_i,
    input  logic [FW_W-1:0] width_i,
    output logic            out_o
);
    lane_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (!en_i) begin
            st_d = '0;
        end else if (adv_i) begin
            st_d.s1 = pin_i;
            st_d.s2 = st_q.s1;
            if (st_q.s2 != st_q.out) begin
                if (st_q.cnt >= width_i) begin
                    st_d.out = st_q.s2;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end else begin
                st_d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_o = en_i && st_q.out;

    AST_DIS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (st_q.out == 1'b0 && st_q.cnt == '0)); // R2
    AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (frz_i && en_i) |=> $stable(st_q)); // R8
    AST_OUT_FROM_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(st_q.out) && $past(en_i)) |-> (st_q.out == $past(st_q.s2))); // R4
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |-> (st_q.cnt <= width_i)); // R4
endmodule

// File: rtl/port_glitch_filter.sv
`timescale 1ns/1ps
module port_glitch_filter
    import pgf_pkg::*;
#(
    parameter int unsigned N_PINS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pin_i,
    input  logic [N_PINS-1:0] en_i,
    input  logic [FW_W-1:0]   width_i,
    input  logic              clk_sel_i,
    input  logic              stop_i,
    input  logic              tick_bus_i,
    input  logic              tick_lp_i,
    output logic [N_PINS-1:0] filt_o
);
    logic              adv;
    logic              frz;
    logic [N_PINS-1:0] lane_out;

    pgf_tick_sel u_tick (
        .clk_sel_i (clk_sel_i),
        .stop_i    (stop_i),
        .tick_bus_i(tick_bus_i),
        .tick_lp_i (tick_lp_i),
        .adv_o     (adv),
        .frz_o     (frz)
    );

    for (genvar g = 0; g < N_PINS; g++) begin : g_lane
        pgf_lane u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_i  (pin_i[g]),
            .en_i   (en_i[g]),
            .adv_i  (adv),
            .frz_i  (frz),
            .width_i(width_i),
            .out_o  (lane_out[g])
        );
    end

    always_comb begin
        filt_o = frz ? (pin_i & en_i) : lane_out;
    end

    AST_FRZ_NO_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        frz |-> !adv); // R7
    AST_LP_NO_FRZ: assert property (@(posedge clk) disable iff (!rst_n)
        clk_sel_i |-> !frz); // R9
endmodule

// File: tb/port_glitch_filter_tb.sv
`timescale 1ns/1ps
module port_glitch_filter_tb_top;
    localparam int unsigned NP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pin = '0;
    logic [NP-1:0] en = '0;
    logic [4:0]    width = '0;
    logic          csel = 1'b0;
    logic          stop = 1'b0;
    logic          tb_bus = 1'b0;
    logic          tb_lp = 1'b0;
    logic [NP-1:0] filt;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    port_glitch_filter #(.N_PINS(NP)) dut_i (
        .clk(clk), .rst_n(rst_n), .pin_i(pin), .en_i(en), .width_i(width),
        .clk_sel_i(csel), .stop_i(stop), .tick_bus_i(tb_bus), .tick_lp_i(tb_lp),
        .filt_o(filt)
    );

    // {sel, width, pulse length, expect pass}
    localparam logic [12:0] VEC [10] = '{
        {1'b0, 5'd0,  6'd1,  1'b1},
        {1'b0, 5'd2,  6'd2,  1'b0},
        {1'b0, 5'd2,  6'd3,  1'b1},
        {1'b1, 5'd3,  6'd3,  1'b0},
        {1'b1, 5'd3,  6'd4,  1'b1},
        {1'b0, 5'd7,  6'd8,  1'b1},
        {1'b0, 5'd7,  6'd7,  1'b0},
        {1'b1, 5'd31, 6'd32, 1'b1},
        {1'b0, 5'd31, 6'd31, 1'b0},
        {1'b1, 5'd1,  6'd1,  1'b0}
    };

    task automatic chk(input string req, input logic [NP-1:0] act, input logic [NP-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    // one selected tick, then one pulse on the other strobe
    task automatic tk();
        @(negedge clk);
        if (csel) tb_lp = 1'b1; else tb_bus = 1'b1;
        @(negedge clk);
        tb_lp = 1'b0; tb_bus = 1'b0;
        if (csel) tb_bus = 1'b1; else tb_lp = 1'b1;
        @(negedge clk);
        tb_lp = 1'b0; tb_bus = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tk();
    endtask

    task automatic setup(input logic sel, input logic [4:0] w, input logic [NP-1:0] e);
        @(negedge clk);
        en = '0;
        @(negedge clk);
        csel = sel; width = w; pin = '0;
        @(negedge clk);
        en = e;
        ticks(4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [NP-1:0] seen;
        pin = '1; en = '1;
        repeat (3) @(negedge clk);
        chk("R2 in reset", filt, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 after reset", filt, '0);

        // vector table: R4 pulse length vs width, R1 tick choice
        for (int v = 0; v < 10; v++) begin
            setup(VEC[v][12], VEC[v][11:7], '1);
            seen = '0;
            pin = '1;
            for (int t = 0; t < int'(VEC[v][6:1]); t++) begin
                tk();
                seen |= filt;
            end
            pin = '0;
            for (int t = 0; t < int'(VEC[v][11:7]) + 5; t++) begin
                tk();
                seen |= filt;
            end
            chk($sformatf("R4 R1 vector %0d", v), seen, {NP{VEC[v][0]}});
        end

        // R1: the unselected strobe alone changes nothing
        setup(1'b0, 5'd0, '1);
        pin = '1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); tb_lp = 1'b1;
            @(negedge clk); tb_lp = 1'b0;
        end
        chk("R1 other strobe ignored", filt, '0);

        // R2: disabled lane ignores its pin
        setup(1'b0, 5'd0, '0);
        pin = '1;
        ticks(6);
        chk("R2 disabled ignores pin", filt, '0);

        // R5 rising and falling latency, W=3
        setup(1'b0, 5'd3, '1);
        pin = '1;
        ticks(5);
        chk("R5 rise not early", filt, '0);
        ticks(1);
        chk("R5 rise at W+3", filt, '1);
        pin = '0;
        ticks(5);
        chk("R5 fall not early", filt, '1);
        ticks(1);
        chk("R5 fall at W+3", filt, '0);

        // R6 width zero
        setup(1'b0, 5'd0, '1);
        pin = '1;
        ticks(2);
        chk("R6 not after 2", filt, '0);
        ticks(1);
        chk("R6 after 3", filt, '1);

        // R2 disable clears at once, re-enable starts at 0
        @(negedge clk);
        en = '0;
        #1;
        chk("R2 disable same cycle", filt, '0);
        @(negedge clk);
        en = '1;
        #1;
        chk("R2 re-enable starts 0", filt, '0);

        // R3 independent enables
        setup(1'b0, 5'd0, 4'b0101);
        pin = '1;
        ticks(4);
        chk("R3 enable mask", filt, 4'b0101);

        // R10 agreement clears count
        setup(1'b0, 5'd4, '1);
        seen = '0;
        pin = '1; for (int i = 0; i < 4; i++) begin tk(); seen |= filt; end
        pin = '0; tk(); seen |= filt;
        pin = '1; for (int i = 0; i < 4; i++) begin tk(); seen |= filt; end
        pin = '0; for (int i = 0; i < 10; i++) begin tk(); seen |= filt; end
        chk("R10 split runs do not pass", seen, '0);

        // R7 / R8 bus-select stop bypass and freeze
        setup(1'b0, 5'd2, 4'b0111);
        pin = '1;
        ticks(6);
        chk("R8 pre-stop settled", filt, 4'b0111);
        @(negedge clk);
        stop = 1'b1; pin = '0;
        #1;
        chk("R7 bypass follows pin low", filt, '0);
        pin = '1;
        #1;
        chk("R7 bypass high, disabled lane 0", filt, 4'b0111);
        pin = '0;
        ticks(10);
        chk("R7 bypass during ticks", filt, '0);
        @(negedge clk);
        stop = 1'b0;
        #1;
        chk("R8 frozen value restored", filt, 4'b0111);
        ticks(4);
        chk("R8 full latency, not early", filt, 4'b0111);
        ticks(1);
        chk("R8 follows after W+3", filt, '0);

        // R9 low-power select: stop does not bypass
        setup(1'b1, 5'd2, '1);
        @(negedge clk);
        stop = 1'b1; pin = '1;
        #1;
        chk("R9 no bypass", filt, '0);
        ticks(4);
        chk("R9 not early", filt, '0);
        ticks(1);
        chk("R9 filters in stop", filt, '1);
        @(negedge clk);
        stop = 1'b0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule